// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block sits between several requesters and one single-ported, word-addressed memory. It turns a linked load followed by a conditional store into an atomic read-modify-write. Each cycle it grants at most one request, using a fixed priority in which the lowest index wins. It drives the memory port from the granted request and returns a registered response one cycle later.

A linked load returns the memory word and opens a reservation for the issuing requester. A later conditional store from that requester writes memory only if the reservation is still open and names the same word. It returns 1 when it writes and 0 when it does not. Any write that lands on a reserved word closes that reservation, whichever requester made the write. Requesters that are not granted must present the same request again in a later cycle.

Opcode encoding on each requester's op field: 2'b00 plain load, 2'b01 plain store, 2'b10 linked load, 2'b11 conditional store.

Top module: `llsc_monitor`

## Requirements
- R1: At most one grant per cycle. The lowest-indexed valid requester is granted in the same cycle, and only the granted request reaches the memory port.
- R2: A granted plain load (op 2'b00) produces, one cycle later, rsp_valid_o set for that requester only and rsp_data_o equal to the memory word at the address.
- R3: A granted plain store (op 2'b01) asserts mem_we_o in its grant cycle with the request's address and data. Its response one cycle later carries data 0.
- R4: A granted linked load (op 2'b10) returns the memory word as in R2 and opens a reservation on that address for the issuing requester.
- R5: A granted conditional store (op 2'b11) whose requester holds an open reservation on the same address writes memory and returns data 1.
- R6: A conditional store with no open reservation leaves mem_we_o low and returns data 0.
- R7: A conditional store always closes its requester's reservation, so a second conditional store right after a successful one fails.
- R8: A conditional store to an address other than the reserved one fails and does not write memory.
- R9: A plain store from any requester, including the holder, to a reserved address closes that reservation.
- R10: A successful conditional store from one requester closes another requester's reservation on the same address.
- R11: Plain loads, linked loads and writes to other addresses leave a reservation open. This includes another requester's linked load to the same address.
- R12: After reset no reservation is open, so a first conditional store fails. rsp_valid_o is low until a request has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request valid, one bit per requester |
| req_op_i | input | 2*N_REQ | Opcode per requester, 2 bits each |
| req_addr_i | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata_i | input | N_REQ*DATA_W | Store data per requester |
| gnt_o | output | N_REQ | Grant, at most one bit set |
| rsp_valid_o | output | N_REQ | Response valid for the requester granted last cycle |
| rsp_data_o | output | DATA_W | Load data or conditional-store flag |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, combinational from mem_addr_o |

## Verification
The hardest case to reach is a reservation lost to the other requester's write at the very address it guards. It has to be set up in a set order: a linked load, then a foreign store or a successful foreign conditional store, then the holder's conditional store. Priority adds to the difficulty, because requester 0 always wins a cycle in which both are valid. Directed sequences build each of these orders explicitly, including simultaneous requests where requester 1 is not granted. A long random run then confines both requesters to four addresses, so reservations collide constantly. A behavioural model checks grant, write enable and response on every cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
  parameter int N_REQ = 2,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_valid_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    any_o     = 1'b0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_valid_i[i]) begin
        gnt_o     = '0;
        gnt_o[i]  = 1'b1;
        gnt_idx_o = IDX_W'(i);
        any_o     = 1'b1;
      end
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R1
  gnt_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_set_i,
  input  logic              cond_clr_i,
  input  logic              wr_commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o
);
  logic hit;
  assign hit = res_valid_o && (res_addr_o == addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
    end else if (link_set_i) begin
      res_valid_o <= 1'b1;
      res_addr_o  <= addr_i;
    end else if (cond_clr_i) begin
      res_valid_o <= 1'b0;
    end else if (wr_commit_i && hit) begin
      res_valid_o <= 1'b0;
    end
  end

  // R4
  link_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_set_i |=> (res_valid_o && res_addr_o == $past(addr_i)));
  // R7
  cond_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_clr_i |=> !res_valid_o);
  // R9
  wr_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit_i && res_valid_o && res_addr_o == addr_i) |=> !res_valid_o);
  // R11
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_set_i && !cond_clr_i && !wr_commit_i) |=> $stable(res_valid_o));
endmodule

// File: rtl/llsc_rsp.sv
module llsc_rsp #(
  parameter int N_REQ  = 2,
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_REQ-1:0]     gnt_i,
  input  llsc_pkg::op_e        op_i,
  input  logic                 cond_ok_i,
  input  logic [DATA_W-1:0]    rdata_i,
  output logic [N_REQ-1:0]     rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_data_o
);
  import llsc_pkg::*;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD, OP_LINK: data_d = rdata_i;
      OP_COND:          data_d = DATA_W'(cond_ok_i);
      default:          data_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= gnt_i;
      if (|gnt_i) rsp_data_o <= data_d;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |=> (rsp_valid_o == $past(gnt_i)));
  // R1
  rsp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int N_REQ  = 2,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_REQ-1:0]          req_valid_i,
  input  logic [2*N_REQ-1:0]        req_op_i,
  input  logic [N_REQ*ADDR_W-1:0]   req_addr_i,
  input  logic [N_REQ*DATA_W-1:0]   req_wdata_i,
  output logic [N_REQ-1:0]          gnt_o,
  output logic [N_REQ-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]         rsp_data_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      mem_we_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [DATA_W-1:0]         mem_rdata_i
);
  import llsc_pkg::*;

  op_e              op_a    [N_REQ];
  logic [ADDR_W-1:0] addr_a [N_REQ];
  logic [DATA_W-1:0] wdata_a[N_REQ];
  logic [N_REQ-1:0]  res_valid;
  logic [ADDR_W-1:0] res_addr[N_REQ];
  logic [IDX_W-1:0]  gnt_idx;
  logic              any_gnt;
  op_e               sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic              cond_ok;
  logic              wr_commit;

  for (genvar i = 0; i < N_REQ; i++) begin : g_unpack
    assign op_a[i]    = op_e'(req_op_i[2*i +: 2]);
    assign addr_a[i]  = req_addr_i[ADDR_W*i +: ADDR_W];
    assign wdata_a[i] = req_wdata_i[DATA_W*i +: DATA_W];
  end

  llsc_arb #(.N_REQ(N_REQ)) i_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .gnt_o       (gnt_o),
    .gnt_idx_o   (gnt_idx),
    .any_o       (any_gnt)
  );

  assign sel_op    = any_gnt ? op_a[gnt_idx] : OP_LOAD;
  assign sel_addr  = addr_a[gnt_idx];
  assign cond_ok   = any_gnt && (sel_op == OP_COND) && res_valid[gnt_idx]
                     && (res_addr[gnt_idx] == sel_addr);
  assign wr_commit = any_gnt && ((sel_op == OP_STORE) || cond_ok);

  assign mem_addr_o  = sel_addr;
  assign mem_we_o    = wr_commit;
  assign mem_wdata_o = wdata_a[gnt_idx];

  for (genvar i = 0; i < N_REQ; i++) begin : g_resv
    llsc_resv #(.ADDR_W(ADDR_W)) i_resv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .link_set_i  (gnt_o[i] && sel_op == OP_LINK),
      .cond_clr_i  (gnt_o[i] && sel_op == OP_COND),
      .wr_commit_i (wr_commit),
      .addr_i      (sel_addr),
      .res_valid_o (res_valid[i]),
      .res_addr_o  (res_addr[i])
    );
  end

  llsc_rsp #(.N_REQ(N_REQ), .DATA_W(DATA_W)) i_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt_o),
    .op_i        (sel_op),
    .cond_ok_i   (cond_ok),
    .rdata_i     (mem_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  // R5
  cond_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_gnt && sel_op == OP_COND) |=> (rsp_data_o == DATA_W'($past(mem_we_o))));
  // R1
  we_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (|gnt_o));
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int N = 2, AW = 10, DW = 32;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] gnt, rsp_valid;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_we;

  logic [DW-1:0] phys [1<<AW];
  logic [DW-1:0] ref_mem [1<<AW];
  assign mem_rdata = phys[mem_addr];
  always @(posedge clk) if (mem_we) phys[mem_addr] <= mem_wdata;

  llsc_monitor i_llsc_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .gnt_o(gnt),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  int vectors = 0, errors = 0;
  bit done = 0;
  bit rv [N];
  int ra [N];
  logic [N-1:0] exp_rv = '0;
  logic [DW-1:0] exp_data = '0;
  string exp_tag = "R12";

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v0, int o0, int a0, int d0,
                      bit v1, int o1, int a1, int d1);
    int g, op, a, d;
    bit sc, we;
    @(negedge clk);
    chk({exp_tag, " rsp_valid"}, DW'(rsp_valid), DW'(exp_rv));
    if (exp_rv != 0) chk({exp_tag, " rsp_data"}, rsp_data, exp_data);
    req_valid = {v1, v0};
    req_op = {2'(o1), 2'(o0)};
    req_addr = {AW'(a1), AW'(a0)};
    req_wdata = {DW'(d1), DW'(d0)};
    #1;
    g = v0 ? 0 : (v1 ? 1 : -1);
    chk({tag, " R1 gnt"}, DW'(gnt), (g < 0) ? 0 : DW'(1 << g));
    if (g < 0) begin
      chk({tag, " R1 idle we"}, DW'(mem_we), 0);
      exp_rv = '0;
      exp_tag = tag;
      return;
    end
    op = g ? o1 : o0; a = g ? a1 : a0; d = g ? d1 : d0;
    sc = (op == 3) && rv[g] && (ra[g] == a);
    we = (op == 1) || sc;
    chk({tag, " R3 we"}, DW'(mem_we), DW'(we));
    if (we) begin
      chk({tag, " R3 addr"}, DW'(mem_addr), DW'(a));
      chk({tag, " R3 wdata"}, mem_wdata, DW'(d));
    end
    exp_rv = '0; exp_rv[g] = 1'b1;
    exp_data = (op == 0 || op == 2) ? ref_mem[a] : ((op == 3) ? DW'(sc) : '0);
    exp_tag = tag;
    if (op == 2) begin rv[g] = 1; ra[g] = a; end
    if (op == 3) rv[g] = 0;
    if (we) begin
      for (int k = 0; k < N; k++) if (rv[k] && ra[k] == a) rv[k] = 0;
      ref_mem[a] = DW'(d);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      phys[i] = DW'(i * 3 + 7); ref_mem[i] = DW'(i * 3 + 7);
    end
    for (int k = 0; k < N; k++) begin rv[k] = 0; ra[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset rsp_valid", DW'(rsp_valid), 0);
    rst_n = 1;
    // R12: conditional store right after reset fails
    step("R12", 1, 3, 5, 32'h11, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    // R2 R4 R5 R7: link, succeed, second cond fails
    step("R2", 1, 0, 5, 0, 0, 0, 0, 0);
    step("R4", 1, 2, 5, 0, 0, 0, 0, 0);
    step("R5", 1, 3, 5, 32'hAA, 0, 0, 0, 0);
    step("R7", 1, 3, 5, 32'hBB, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, 0, 5, 0);
    // R8: mismatched address
    step("R4", 1, 2, 6, 0, 0, 0, 0, 0);
    step("R8", 1, 3, 7, 32'h77, 0, 0, 0, 0);
    step("R2", 1, 0, 7, 0, 0, 0, 0, 0);
    // R9: foreign plain store kills, own plain store kills
    step("R4", 0, 0, 0, 0, 1, 2, 9, 0);
    step("R9", 1, 1, 9, 32'h99, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 3, 9, 32'h55);
    step("R4", 1, 2, 10, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 10, 32'h10, 0, 0, 0, 0);
    step("R9", 1, 3, 10, 32'h20, 0, 0, 0, 0);
    // R10: both link same addr, req0 wins cond, req1 fails
    step("R4", 1, 2, 12, 0, 0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 2, 12, 0);
    step("R10", 1, 3, 12, 32'hC0, 1, 3, 12, 32'hC1);
    step("R10", 0, 0, 0, 0, 1, 3, 12, 32'hC1);
    // R11: loads, other links, other-address stores keep reservation
    step("R4", 0, 0, 0, 0, 1, 2, 14, 0);
    step("R11", 1, 0, 14, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 15, 32'h15, 0, 0, 0, 0);
    step("R11", 1, 2, 14, 0, 0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 3, 14, 32'hE1);
    step("R2", 1, 0, 14, 0, 0, 0, 0, 0);
    // R1: simultaneous requests, req1 not granted
    step("R1", 1, 1, 20, 32'h1, 1, 1, 21, 32'h2);
    step("R3", 1, 0, 21, 0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      step("RND", $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom, $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom);
    end
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule